// File: doc/BRIEF.md
# GPIO Bank Register File

This block holds the data and interrupt registers of a GPIO controller organised as banks of 32 pins. Each bank has an output latch that software changes through separate set and clear addresses, a read view of the latch and a read view of the synchronised pad inputs, a pending-interrupt register cleared by writing ones, and an interrupt mask with separate addresses for masking and unmasking. Each pin also has a control word whose bit 0 holds its direction. Since every modifying access touches only the bits written as one, software never needs a read-modify-write sequence.

Pending bits are raised by single-cycle pulses from a separate edge-detection block. Every write is qualified bit by bit with a per-pin unlocked vector from a separate lock unit. Each bank drives one combined interrupt line. The pad output enable is the inverse of the direction bit.

Top module: `gpio_bank_regfile`

## Requirements
- R1: After reset every pin is an input (control word bit 0 reads 1, pad_oe all zero), the output latch is zero, every mask bit reads 1, every pending bit reads 0 and no bank interrupt is asserted.
- R2: A write to a bank's output-set address (0x40 + 4·bank) drives the latch bits written as 1 high, from the clock edge that takes the write; bits written as 0 keep their value.
- R3: A write to a bank's output-clear address (0x60 + 4·bank) drives the latch bits written as 1 low; bits written as 0 keep their value.
- R4: A one-cycle pulse on pin_edge sets that pin's pending bit (readable at 0x80 + 4·bank); writing 1s to that address clears those pending bits, 0 bits have no effect, and a pulse in the same cycle as a clearing write leaves the bit set.
- R5: Writing 1s to the mask address (0xA0 + 4·bank) masks those pins; writing 1s to the mask-clear address (0xC0 + 4·bank) unmasks them; 0 bits have no effect.
- R6: bank_irq[b] is high exactly while some pending bit of bank b has its mask bit at 0.
- R7: Each pin p has a control word at 0x100 + 4·p whose bit 0 is the direction (1 input, 0 output); pad_oe[p] is the inverse of that bit.
- R8: A write has no effect on any latch, mask, pending or direction bit whose pin_unlocked bit is 0.
- R9: The input-status address (0x20 + 4·bank) returns the pad inputs through a two-flop synchronizer: a read registered at the second clock edge after a pad change still returns the old value, one registered at the third returns the new one.
- R10: bus_rdata is loaded at the clock edge that samples bus_rd and holds otherwise; the output-status address (0x00 + 4·bank) returns the latch, and the set, clear and mask-clear addresses and unmapped addresses read as zero.
- R11: Addresses for banks at or above NUM_BANKS, register group offset 0xE0 and control words for pins at or above the pin count are ignored on write and read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| pin_unlocked | input | NUM_BANKS·32 | Per-pin write permission from the lock unit |
| pin_edge | input | NUM_BANKS·32 | Per-pin pending-set pulses from edge detection |
| pad_in | input | NUM_BANKS·32 | Asynchronous pad input levels |
| pad_out | output | NUM_BANKS·32 | Output latch to the pads |
| pad_oe | output | NUM_BANKS·32 | Pad output enable, 1 drives the pin |
| bank_irq | output | NUM_BANKS | Combined interrupt per bank |

## Verification
Register writes and edge pulses land at the clock edge that samples them, so pad_out, pad_oe and bank_irq are compared at the falling edge right after that edge, where the driver tasks return. A read is registered at the edge sampling bus_rd and compared by the monitor at the following falling edge, popping the expected word the driver queued. Input-status changes need two more edges through the synchronizer, so the bench issues three back-to-back reads after a pad change and expects old, old, new.

// File: rtl/gpio_bank_pkg.sv
// Shared definitions of the GPIO bank register file.
// Assumes 32 pins per bank and a byte-addressed word bus.
package gpio_bank_pkg;
    localparam int unsigned PINS_PER_BANK = 32;
    localparam int unsigned CTL_BASE      = 32'h100;

    // Register group, taken from address bits [7:5] in the bank area.
    typedef enum logic [2:0] {
        GRP_OUT  = 3'd0,
        GRP_IN   = 3'd1,
        GRP_SET  = 3'd2,
        GRP_CLR  = 3'd3,
        GRP_STAT = 3'd4,
        GRP_MASK = 3'd5,
        GRP_MCLR = 3'd6,
        GRP_NONE = 3'd7
    } reg_grp_e;
endpackage

// File: rtl/gpio_addr_decode.sv
// Address decoder: splits a byte address into a bank register group and
// bank index, or a per-pin control word index.
// Assumes word-aligned accesses; the two low address bits are ignored.
module gpio_addr_decode
    import gpio_bank_pkg::*;
#(
    parameter int NUM_BANKS = 2,
    parameter int ADDR_W    = 12,
    localparam int NPINS    = NUM_BANKS * PINS_PER_BANK,
    localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
    localparam int PIN_W    = $clog2(NPINS)
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_grp_e          grp,
    output logic [BANK_W-1:0] bank,
    output logic              ctl_hit,
    output logic [PIN_W-1:0]  ctl_pin
);
    localparam logic [ADDR_W-1:0] CTL_BASE_A = ADDR_W'(CTL_BASE);

    logic [ADDR_W-1:0] pin_off;
    logic              unused_lsb;

    assign unused_lsb = ^addr[1:0];
    assign pin_off    = (addr - CTL_BASE_A) >> 2;

    // Purpose: classify the address into bank area or control area.
    always_comb begin
        grp     = GRP_NONE;
        bank    = '0;
        ctl_hit = 1'b0;
        ctl_pin = '0;
        if (addr < CTL_BASE_A) begin
            if ((int'(addr[4:2]) < NUM_BANKS) && (addr[7:5] != 3'd7)) begin
                grp  = reg_grp_e'(addr[7:5]);
                bank = addr[2 +: BANK_W];
            end
        end else begin
            if (int'(pin_off) < NPINS) begin
                ctl_hit = 1'b1;
                ctl_pin = pin_off[PIN_W-1:0];
            end
        end
    end
endmodule

// File: rtl/gpio_in_sync.sv
// Two-flop synchronizer for the asynchronous pad inputs.
// Assumes each pin is sampled independently; no cross-bit coherence.
module gpio_in_sync #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;
    logic [1:0]   warm;

    // Purpose: move pad levels through two flops into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end

    // Purpose: count edges since reset so the latency check starts valid.
    always_ff @(posedge clk) begin
        if (!rst_n)             warm <= 2'd0;
        else if (warm != 2'd2)  warm <= warm + 2'd1;
    end

    // R9: output equals the pad level two edges earlier
    a_r9_two_stage: assert property (@(posedge clk) disable iff (!rst_n)
        (warm == 2'd2) |-> (q == $past(d, 2)));
endmodule

// File: rtl/gpio_bank_regs.sv
// Register state of one 32-pin bank: output latch, pending bits, mask and
// per-pin direction. Write strobes arrive decoded; every write is
// qualified bit by bit with the unlocked vector.
// Assumes at most one write strobe is active per cycle.
module gpio_bank_regs #(
    parameter int PINS = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PINS-1:0] wdata,
    input  logic [PINS-1:0] unl,
    input  logic [PINS-1:0] evt,
    input  logic            we_set,
    input  logic            we_clr,
    input  logic            we_stat,
    input  logic            we_mask,
    input  logic            we_mclr,
    input  logic [PINS-1:0] ctl_we,
    input  logic            ctl_dir,
    output logic [PINS-1:0] out_q,
    output logic [PINS-1:0] dir_q,
    output logic [PINS-1:0] stat_q,
    output logic [PINS-1:0] mask_q,
    output logic            irq
);
    logic [PINS-1:0] wq;

    assign wq = wdata & unl;

    // Purpose: output latch with separate set and clear ports.
    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= (out_q | (we_set ? wq : '0)) & ~(we_clr ? wq : '0);
    end

    // Purpose: pending bits, event pulses win over a clearing write.
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= (stat_q & ~(we_stat ? wq : '0)) | evt;
    end

    // Purpose: interrupt mask with separate mask and unmask ports.
    always_ff @(posedge clk) begin
        if (!rst_n) mask_q <= '1;
        else        mask_q <= (mask_q | (we_mask ? wq : '0)) & ~(we_mclr ? wq : '0);
    end

    // Purpose: combined bank interrupt from unmasked pending bits.
    assign irq = |(stat_q & ~mask_q);

    for (genvar i = 0; i < PINS; i++) begin : g_pin
        // Purpose: direction bit from the pin's control word.
        always_ff @(posedge clk) begin
            if (!rst_n)                   dir_q[i] <= 1'b1;
            else if (ctl_we[i] && unl[i]) dir_q[i] <= ctl_dir;
        end

        // R2: set write raises an unlocked bit
        a_r2_set_high: assert property (@(posedge clk) disable iff (!rst_n)
            (we_set && wdata[i] && unl[i]) |=> out_q[i]);
        // R3: clear write lowers an unlocked bit
        a_r3_clr_low: assert property (@(posedge clk) disable iff (!rst_n)
            (we_clr && wdata[i] && unl[i]) |=> !out_q[i]);
        // R4: an event pulse always leaves the pending bit set
        a_r4_evt_pending: assert property (@(posedge clk) disable iff (!rst_n)
            evt[i] |=> stat_q[i]);
        // R5: mask-clear write unmasks an unlocked bit
        a_r5_unmask: assert property (@(posedge clk) disable iff (!rst_n)
            (we_mclr && wdata[i] && unl[i]) |=> !mask_q[i]);
        // R8: a locked pin keeps latch, mask and direction
        a_r8_locked_hold: assert property (@(posedge clk) disable iff (!rst_n)
            !unl[i] |=> ($stable(out_q[i]) && $stable(mask_q[i]) && $stable(dir_q[i])));
    end
endmodule

// File: rtl/gpio_bank_regfile.sv
// GPIO bank register file top: decodes the register bus, instantiates one
// register set per bank, synchronises pad inputs and returns read data one
// cycle after the read strobe.
// Assumes bus_wr and bus_rd carry one access per cycle, word aligned.
module gpio_bank_regfile
    import gpio_bank_pkg::*;
#(
    parameter int NUM_BANKS = 2,
    parameter int ADDR_W    = 12,
    localparam int NPINS    = NUM_BANKS * PINS_PER_BANK,
    localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
    localparam int PIN_W    = $clog2(NPINS)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     bus_wr,
    input  logic                     bus_rd,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic [PINS_PER_BANK-1:0] bus_wdata,
    output logic [PINS_PER_BANK-1:0] bus_rdata,
    input  logic [NPINS-1:0]         pin_unlocked,
    input  logic [NPINS-1:0]         pin_edge,
    input  logic [NPINS-1:0]         pad_in,
    output logic [NPINS-1:0]         pad_out,
    output logic [NPINS-1:0]         pad_oe,
    output logic [NUM_BANKS-1:0]     bank_irq
);
    reg_grp_e                 grp;
    logic [BANK_W-1:0]        bank;
    logic                     ctl_hit;
    logic [PIN_W-1:0]         ctl_pin;
    logic [NPINS-1:0]         ctl_we_all;
    logic [NPINS-1:0]         dir_all;
    logic [NPINS-1:0]         in_sync;
    logic [PINS_PER_BANK-1:0] out_b  [NUM_BANKS];
    logic [PINS_PER_BANK-1:0] stat_b [NUM_BANKS];
    logic [PINS_PER_BANK-1:0] mask_b [NUM_BANKS];
    logic [PINS_PER_BANK-1:0] in_b   [NUM_BANKS];
    logic [PINS_PER_BANK-1:0] rd_val;

    gpio_addr_decode #(
        .NUM_BANKS (NUM_BANKS),
        .ADDR_W    (ADDR_W)
    ) u_dec (
        .addr    (bus_addr),
        .grp     (grp),
        .bank    (bank),
        .ctl_hit (ctl_hit),
        .ctl_pin (ctl_pin)
    );

    gpio_in_sync #(.W(NPINS)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pad_in),
        .q     (in_sync)
    );

    // Purpose: one-hot control-word write strobe for the addressed pin.
    always_comb begin
        ctl_we_all = '0;
        if (bus_wr && ctl_hit) ctl_we_all[ctl_pin] = 1'b1;
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic sel;
        assign sel = (bank == BANK_W'(b));

        gpio_bank_regs #(.PINS(PINS_PER_BANK)) u_regs (
            .clk     (clk),
            .rst_n   (rst_n),
            .wdata   (bus_wdata),
            .unl     (pin_unlocked[b*PINS_PER_BANK +: PINS_PER_BANK]),
            .evt     (pin_edge[b*PINS_PER_BANK +: PINS_PER_BANK]),
            .we_set  (bus_wr && sel && (grp == GRP_SET)),
            .we_clr  (bus_wr && sel && (grp == GRP_CLR)),
            .we_stat (bus_wr && sel && (grp == GRP_STAT)),
            .we_mask (bus_wr && sel && (grp == GRP_MASK)),
            .we_mclr (bus_wr && sel && (grp == GRP_MCLR)),
            .ctl_we  (ctl_we_all[b*PINS_PER_BANK +: PINS_PER_BANK]),
            .ctl_dir (bus_wdata[0]),
            .out_q   (out_b[b]),
            .dir_q   (dir_all[b*PINS_PER_BANK +: PINS_PER_BANK]),
            .stat_q  (stat_b[b]),
            .mask_q  (mask_b[b]),
            .irq     (bank_irq[b])
        );

        assign pad_out[b*PINS_PER_BANK +: PINS_PER_BANK] = out_b[b];
        assign in_b[b] = in_sync[b*PINS_PER_BANK +: PINS_PER_BANK];
    end

    assign pad_oe = ~dir_all;

    // Purpose: select the word returned for the current read address.
    always_comb begin
        rd_val = '0;
        if (ctl_hit) begin
            rd_val = {{(PINS_PER_BANK-1){1'b0}}, dir_all[ctl_pin]};
        end else begin
            case (grp)
                GRP_OUT:  rd_val = out_b[bank];
                GRP_IN:   rd_val = in_b[bank];
                GRP_STAT: rd_val = stat_b[bank];
                GRP_MASK: rd_val = mask_b[bank];
                default:  rd_val = '0;
            endcase
        end
    end

    // Purpose: register read data on the read strobe, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_val;
    end

    // R7: pad direction only moves on a bus write
    a_r7_oe_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> $stable(pad_oe));
    // R6: with no write and no event the bank interrupts hold
    a_r6_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_wr && (pin_edge == '0)) |=> $stable(bank_irq));
    // R10: read data changes only after a read strobe
    a_r10_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));
endmodule

// File: tb/gpio_bank_regfile_tb_top.sv
// Scoreboard bench: read tasks queue expected words, a monitor pops and
// compares them one cycle after each read strobe.
module gpio_bank_regfile_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NB = 2;
    localparam int NP = NB * 32;

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } sb_item_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0;
    logic          bus_rd = 1'b0;
    logic [11:0]   bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NP-1:0] pin_unlocked = '1;
    logic [NP-1:0] pin_edge = '0;
    logic [NP-1:0] pad_in = 64'h1234_5678_9ABC_DEF0;
    logic [NP-1:0] pad_out;
    logic [NP-1:0] pad_oe;
    logic [NB-1:0] bank_irq;

    int       n_checks = 0;
    int       n_fail = 0;
    bit       done = 1'b0;
    logic     rd_pend = 1'b0;
    sb_item_t sb_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_bank_regfile #(.NUM_BANKS(NB), .ADDR_W(12)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_wr       (bus_wr),
        .bus_rd       (bus_rd),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .pin_unlocked (pin_unlocked),
        .pin_edge     (pin_edge),
        .pad_in       (pad_in),
        .pad_out      (pad_out),
        .pad_oe       (pad_oe),
        .bank_irq     (bank_irq)
    );

    function automatic logic [11:0] ra(input int grp, input int bank);
        return 12'(grp * 32 + bank * 4);
    endfunction

    function automatic logic [11:0] ca(input int pin);
        return 12'(256 + pin * 4);
    endfunction

    task automatic chk(input logic [63:0] got, input logic [63:0] exp, input string tag);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, input logic [31:0] e, input string tag);
        sb_item_t it;
        it.exp = e; it.tag = tag;
        sb_q.push_back(it);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic pulse(input logic [NP-1:0] p);
        pin_edge = p;
        @(negedge clk);
        pin_edge = '0;
    endtask

    // Monitor: track read strobes taken at the rising edge.
    always @(posedge clk) rd_pend <= bus_rd;

    // Monitor: compare the registered read data with the queued word.
    always @(negedge clk) begin
        if (rd_pend) begin
            if (sb_q.size() == 0) begin
                n_checks++; n_fail++;
                $display("FAIL R10: read data %h with no expected word", bus_rdata);
            end else begin
                sb_item_t it;
                it = sb_q.pop_front();
                chk({32'd0, bus_rdata}, {32'd0, it.exp}, it.tag);
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk(pad_oe, '0, "R1 pad_oe");
        chk(pad_out, '0, "R1 pad_out");
        chk({62'd0, bank_irq}, 64'd0, "R1 bank_irq");
        rd(ra(5, 0), 32'hFFFF_FFFF, "R1 mask reset");
        rd(ra(4, 1), 32'h0, "R1 pending reset");
        rd(ca(5), 32'h1, "R1 direction reset");

        // R7 direction and output enable
        wr(ca(3), 32'h0);
        chk(pad_oe, 64'h8, "R7 oe pin3");
        wr(ca(40), 32'hFFFF_FFFE);
        chk(pad_oe, 64'h0000_0100_0000_0008, "R7 oe pin40");
        rd(ca(3), 32'h0, "R7 read ctl pin3");

        // R2 set, zeros keep value
        wr(ra(2, 0), 32'h0000_00F0);
        chk(pad_out, 64'hF0, "R2 set F0");
        wr(ra(2, 0), 32'h0000_000F);
        chk(pad_out, 64'hFF, "R2 set 0F keeps F0");
        rd(ra(0, 0), 32'h0000_00FF, "R10 output status");

        // R3 clear, zeros keep value; R11 bank stride
        wr(ra(3, 0), 32'h0000_003C);
        chk(pad_out, 64'hC3, "R3 clear 3C");
        wr(ra(2, 1), 32'h8000_0001);
        chk(pad_out, 64'h8000_0001_0000_00C3, "R11 set bank1");
        rd(ra(0, 1), 32'h8000_0001, "R11 bank1 output status");

        // R8 locked pin 1
        pin_unlocked[1] = 1'b0;
        wr(ra(3, 0), 32'hFFFF_FFFF);
        chk(pad_out, 64'h8000_0001_0000_0002, "R8 locked latch bit");
        wr(ra(6, 0), 32'hFFFF_FFFF);
        wr(ca(1), 32'h0);
        chk(pad_oe, 64'h0000_0100_0000_0008, "R8 locked direction");
        rd(ra(5, 0), 32'h0000_0002, "R8 locked mask bit");
        pin_unlocked = '1;

        // R4 pending set by event; R6 interrupt
        pulse(64'h10);
        chk({62'd0, bank_irq}, 64'd1, "R6 irq after event");
        rd(ra(4, 0), 32'h0000_0010, "R4 pending bit4");

        // R5 mask / unmask
        wr(ra(5, 0), 32'h0000_0010);
        chk({62'd0, bank_irq}, 64'd0, "R5 masked irq low");
        rd(ra(5, 0), 32'h0000_0012, "R5 mask read");
        wr(ra(6, 0), 32'h0000_0010);
        chk({62'd0, bank_irq}, 64'd1, "R5 unmasked irq high");

        // R4 write-one-to-clear, zero bits ignored
        wr(ra(4, 0), 32'hFFFF_FFEF);
        rd(ra(4, 0), 32'h0000_0010, "R4 zero bits ignored");
        wr(ra(4, 0), 32'h0000_0010);
        chk({62'd0, bank_irq}, 64'd0, "R4 cleared irq low");

        // R4 event in same cycle as clear wins
        pin_edge = 64'h80;
        bus_wr = 1'b1; bus_addr = ra(4, 0); bus_wdata = 32'h0000_0080;
        @(negedge clk);
        bus_wr = 1'b0; pin_edge = '0;
        rd(ra(4, 0), 32'h0000_0080, "R4 event beats clear");
        chk({62'd0, bank_irq}, 64'd1, "R6 irq from bit7");
        wr(ra(4, 0), 32'hFFFF_FFFF);
        chk({62'd0, bank_irq}, 64'd0, "R6 irq after clear");

        // R9 synchronizer latency
        pad_in[63:32] = 32'hCAFE_0001;
        rd(ra(1, 1), 32'h1234_5678, "R9 first read old");
        rd(ra(1, 1), 32'h1234_5678, "R9 second read old");
        rd(ra(1, 1), 32'hCAFE_0001, "R9 third read new");

        // R10 write-only and unmapped reads, R11 out-of-range accesses
        rd(ra(2, 0), 32'h0, "R10 set reads zero");
        rd(ra(6, 0), 32'h0, "R10 mask-clear reads zero");
        rd(ra(7, 0), 32'h0, "R11 group E0 reads zero");
        rd(ra(0, 2), 32'h0, "R11 bank2 reads zero");
        wr(ra(2, 2), 32'hFFFF_FFFF);
        chk(pad_out, 64'h8000_0001_0000_0002, "R11 bank2 write ignored");
        wr(ca(64), 32'h0);
        chk(pad_oe, 64'h0000_0100_0000_0008, "R11 pin64 write ignored");

        repeat (3) @(negedge clk);
        if (sb_q.size() != 0) begin
            n_checks++; n_fail++;
            $display("FAIL R10: %0d reads never returned, expected 0", sb_q.size());
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule